// File: doc/BRIEF.md
# Cumulative Thermal Assertion Timer

This block measures how long an active-low thermal input has been held asserted. The lengths of separate low periods are added together in an 8-bit register. The input passes through a synchronizer. A prescaler divides the clock into ticks of a programmable number of cycles, and the register counts whole ticks of assertion time. The register saturates at full scale. A host read strobe returns the current value and clears it in the same cycle.

Right after a clear, the register first acts as a marker. The first cycle of assertion makes it read 1, before any tick has elapsed. Once a full tick has accumulated, the register is a plain count of whole ticks. A read that lands while the input is still low clears the count, sets the marker again and restarts the tick count from zero.

The accumulated value is compared with a writable 8-bit threshold. When the value is strictly greater than the threshold, a sticky status flag is set. The flag drives an active-low alert output and stays set until a separate clear strobe removes it.

Top module: `hot_pin_timer`

## Requirements
- R1: After reset, a read returns 0x00, the alert output is high, and the threshold is 0xFF.
- R2: The input is active low and passes through a two-flop synchronizer. Counting runs only while the synchronized input is low and holds while it is high. Separate low periods add up: TICK_CYC counted cycles make one tick.
- R3: After a clear, the first counted cycle of assertion makes the value read 0x01, before any whole tick has elapsed.
- R4: Once at least one whole tick has accumulated, the value is the number of whole ticks, with bit 0 as the LSB. For example, 24 counted cycles with TICK_CYC of 8 read as 0x03.
- R5: The value saturates at 0xFF and stays there while assertion continues.
- R6: A read strobe places the value into the read data output on the next clock edge. In the same edge it clears the value and the sub-tick prescaler. The read data output holds when no read strobe is given.
- R7: A read on an edge where the synchronized input is low leaves the value at 0x01, and tick counting restarts from zero.
- R8: The threshold is written through the limit write port. The status flag is set on the edge after the value is strictly greater than the threshold. A value equal to the threshold does not set it.
- R9: With a threshold of 0x00, the first assertion sets the status flag. This includes the restarted marker left by a read made during assertion.
- R10: The status flag is sticky. Reading the timer does not clear it; only the clear strobe does. When a clear strobe and an exceed condition fall in the same cycle, the flag stays set.
- R11: The alert output is low exactly while the status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hot_n_i | input | 1 | Asynchronous active-low thermal input |
| rd_stb_i | input | 1 | One-cycle read strobe; returns and clears the timer |
| rd_data_o | output | 8 | Timer value captured by the last read |
| lim_we_i | input | 1 | Threshold write enable |
| lim_data_i | input | 8 | Threshold write data |
| stat_clr_i | input | 1 | One-cycle status flag clear strobe |
| alert_n_o | output | 1 | Active-low alert, low while the status flag is set |

## Verification
Two pairs of actions can fall on the same edge.

The first pair is a host read and an active assertion. The bench holds the input low and releases it so that the read edge is the last edge at which the synchronized input is still low. It expects the first read to return the whole-tick count, and a later read to return the restarted marker 0x01 rather than 0x00.

The second pair is the status clear and a standing exceed condition. The bench keeps the value above the threshold, pulses the clear strobe, and expects the alert to stay low. With a zero threshold, a clear given after a mid-assertion read must also leave the alert low.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int VAL_W_DEF  = 8;
  localparam int SYNC_DEF   = 2;
  localparam int TICK_DEF   = 227600;

  function automatic logic [VAL_W_DEF-1:0] sat_inc(input logic [VAL_W_DEF-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction
endpackage

// File: rtl/hpt_sync.sv
module hpt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  output logic active_o
);
  logic [STAGES-1:0] sh_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh_q[g] <= 1'b1;
          else     sh_q[g] <= pin_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh_q[g] <= 1'b1;
          else     sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign active_o = ~sh_q[STAGES-1];
endmodule

// File: rtl/hpt_accum.sv
module hpt_accum
  import hpt_pkg::*;
#(
  parameter int TICK_CYC = TICK_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active_i,
  input  logic                 clr_i,
  output logic [VAL_W_DEF-1:0] value_o
);
  localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYC - 1);
  localparam logic [VAL_W_DEF-1:0] FULL = '1;

  logic [PW-1:0]        pre_q;
  logic [VAL_W_DEF-1:0] ticks_q;
  logic                 seen_q;
  logic                 tick_done;

  assign tick_done = active_i && (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= '0;
      ticks_q <= '0;
      seen_q  <= 1'b0;
    end else if (clr_i) begin
      pre_q   <= '0;
      ticks_q <= '0;
      seen_q  <= active_i;
    end else if (active_i) begin
      seen_q <= 1'b1;
      if (tick_done) begin
        pre_q   <= '0;
        ticks_q <= sat_inc(ticks_q);
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign value_o = (ticks_q == '0 && seen_q) ? VAL_W_DEF'(1) : ticks_q;

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!active_i && !clr_i) |=> $stable(value_o));
  assert_sat_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (ticks_q == FULL && !clr_i) |=> (ticks_q == FULL));
  assert_clear_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !active_i) |=> (value_o == '0));
  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && active_i) |=> (value_o == VAL_W_DEF'(1)));
endmodule

// File: rtl/hpt_status.sv
module hpt_status
  import hpt_pkg::*;
#(
  parameter logic [VAL_W_DEF-1:0] LIM_RST = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [VAL_W_DEF-1:0] value_i,
  input  logic                 lim_we_i,
  input  logic [VAL_W_DEF-1:0] lim_data_i,
  input  logic                 clr_i,
  output logic                 stat_o
);
  logic [VAL_W_DEF-1:0] lim_q;
  logic                 stat_q;
  logic                 exceed;

  assign exceed = value_i > lim_q;

  always_ff @(posedge clk) begin
    if (rst)           lim_q <= LIM_RST;
    else if (lim_we_i) lim_q <= lim_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= 1'b0;
    else     stat_q <= (stat_q && !clr_i) || exceed;
  end

  assign stat_o = stat_q;

  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (stat_q && !clr_i) |=> stat_q);
  assert_set_on_exceed_R8: assert property (@(posedge clk) disable iff (rst)
    (value_i > lim_q) |=> stat_q);
  assert_no_set_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!stat_q && !(value_i > lim_q)) |=> !stat_q);
endmodule

// File: rtl/hot_pin_timer.sv
module hot_pin_timer
  import hpt_pkg::*;
#(
  parameter int                   TICK_CYC = TICK_DEF,
  parameter int                   SYNC_STG = SYNC_DEF,
  parameter logic [VAL_W_DEF-1:0] LIM_RST  = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hot_n_i,
  input  logic                 rd_stb_i,
  output logic [VAL_W_DEF-1:0] rd_data_o,
  input  logic                 lim_we_i,
  input  logic [VAL_W_DEF-1:0] lim_data_i,
  input  logic                 stat_clr_i,
  output logic                 alert_n_o
);
  logic                 active;
  logic [VAL_W_DEF-1:0] value;
  logic                 stat;
  logic [VAL_W_DEF-1:0] rd_q;

  hpt_sync #(.STAGES(SYNC_STG)) i_sync (
    .clk(clk), .rst(rst), .pin_n_i(hot_n_i), .active_o(active)
  );

  hpt_accum #(.TICK_CYC(TICK_CYC)) i_accum (
    .clk(clk), .rst(rst), .active_i(active), .clr_i(rd_stb_i), .value_o(value)
  );

  hpt_status #(.LIM_RST(LIM_RST)) i_status (
    .clk(clk), .rst(rst), .value_i(value), .lim_we_i(lim_we_i),
    .lim_data_i(lim_data_i), .clr_i(stat_clr_i), .stat_o(stat)
  );

  always_ff @(posedge clk) begin
    if (rst)           rd_q <= '0;
    else if (rd_stb_i) rd_q <= value;
  end

  assign rd_data_o = rd_q;
  assign alert_n_o = ~stat;

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_stb_i |=> $stable(rd_data_o));
  assert_rd_capture_R6: assert property (@(posedge clk) disable iff (rst)
    rd_stb_i |=> (rd_data_o == $past(value)));
endmodule

// File: tb/test_hot_pin_timer.sv
module test_hot_pin_timer;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hot_n = 1'b1;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic       lim_we = 1'b0;
  logic [7:0] lim_data = '0;
  logic       stat_clr = 1'b0;
  logic       alert_n;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit rd_seen = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  hot_pin_timer #(.TICK_CYC(TICK)) i_hot_pin_timer (
    .clk(clk), .rst(rst), .hot_n_i(hot_n), .rd_stb_i(rd_stb),
    .rd_data_o(rd_data), .lim_we_i(lim_we), .lim_data_i(lim_data),
    .stat_clr_i(stat_clr), .alert_n_o(alert_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) rd_seen <= rd_stb;

  // monitor: pops expected read values as results appear
  always @(negedge clk) begin
    if (rd_seen) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL read with empty scoreboard: actual=%h expected=none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          bad++;
          $display("FAIL %s read: actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  task automatic do_read(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_low(input int n);
    hot_n = 1'b0;
    repeat (n) @(negedge clk);
    hot_n = 1'b1;
  endtask

  task automatic set_lim(input logic [7:0] v);
    lim_data = v;
    lim_we = 1'b1;
    @(negedge clk);
    lim_we = 1'b0;
  endtask

  task automatic pulse_clr();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  task automatic chk_alert(input logic e, input string t);
    total++;
    if (alert_n !== e) begin
      bad++;
      $display("FAIL %s alert_n: actual=%b expected=%b", t, alert_n, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_alert(1'b1, "R1");
    total++;
    if (rd_data !== 8'h00) begin
      bad++;
      $display("FAIL R1 rd_data after reset: actual=%h expected=00", rd_data);
    end
    do_read(8'h00, "R1");
    idle(2);
    // R3 marker before a whole tick
    hold_low(3); idle(4);
    do_read(8'h01, "R3");
    // R2 cumulative, pauses while high: 10 + 14 = 24 cycles -> 3 ticks (R4)
    hold_low(10); idle(5); hold_low(14); idle(4);
    do_read(8'h03, "R2_R4");
    // R4 plain count: 40 cycles -> 5 ticks
    hold_low(40); idle(4);
    do_read(8'h05, "R4");
    // R6 prescaler cleared on read: 15 then 9 cycles
    hold_low(15); idle(4);
    do_read(8'h01, "R6");
    hold_low(9); idle(4);
    do_read(8'h01, "R6_prescaler");
    idle(2);
    total++;
    if (rd_data !== 8'h01) begin
      bad++;
      $display("FAIL R6 rd_data hold: actual=%h expected=01", rd_data);
    end
    // R7 read on the last low edge: 19 counted before -> 2, then marker 1
    hot_n = 1'b0;
    idle(20);
    hot_n = 1'b1;
    idle(1);
    do_read(8'h02, "R7_first");
    idle(5);
    do_read(8'h01, "R7_restart");
    // R5 saturation, threshold FF never exceeded (R8 boundary)
    hold_low(2100); idle(3); hold_low(30); idle(4);
    chk_alert(1'b1, "R8_equal_ff");
    do_read(8'hFF, "R5");
    // R8 threshold 3: equal does not set, greater sets
    set_lim(8'h03);
    hold_low(24); idle(4);
    chk_alert(1'b1, "R8_equal");
    hold_low(8); idle(4);
    chk_alert(1'b0, "R8_exceed");
    do_read(8'h04, "R8");
    idle(2);
    chk_alert(1'b0, "R10_read_no_clear");
    pulse_clr(); idle(1);
    chk_alert(1'b1, "R10_clear");
    // R10 clear while exceed still stands
    hold_low(40); idle(4);
    chk_alert(1'b0, "R8_exceed2");
    pulse_clr(); idle(1);
    chk_alert(1'b0, "R10_coincide");
    do_read(8'h05, "R10");
    idle(1);
    pulse_clr(); idle(1);
    chk_alert(1'b1, "R11_release");
    // R9 zero threshold
    set_lim(8'h00);
    hold_low(1); idle(4);
    chk_alert(1'b0, "R9_first");
    do_read(8'h01, "R9");
    idle(1);
    pulse_clr(); idle(1);
    chk_alert(1'b1, "R9_cleared");
    hot_n = 1'b0;
    idle(20);
    hot_n = 1'b1;
    idle(1);
    do_read(8'h02, "R9_midread");
    idle(2);
    pulse_clr(); idle(2);
    chk_alert(1'b0, "R9_restart");
    do_read(8'h01, "R9_marker");
    idle(3);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard left items: actual=%0d expected=0", exp_q.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule